// File: doc/BRIEF.md
# Reference-Aligned Multiframe Clock Counter

This block keeps the local multiframe timing of a converter link receiver. It runs on the link character clock, where one cycle carries one octet. It counts octets into frames and frames into multiframes, using a frame length and a multiframe length that are set at run time. From that count it drives a frame strobe, a multiframe strobe and the current frame index. It also drives a release strobe that tells the lane elastic buffers when to hand their data on, at a fixed frame offset inside the multiframe.

The multiframe phase does not run freely. An external system reference pulse is synchronised into the clock domain, and each accepted rising edge forces the counter to the start of a multiframe. Every device that sees the same reference therefore lands on the same phase, and the delay through the link is the same after every reset.

An edge that lands exactly where the counter would have wrapped anyway leaves the phase as it was. An edge anywhere else moves the phase and raises an "adjusted" flag. A mode input picks between two behaviours: accept every reference edge, or accept only the first edge after the block is armed.

Top module: `mfclk_align`

## Requirements
- R1: While `rst` is high at a clock edge, every output reads 0 after that edge and the octet and frame positions return to 0.
- R2: `sysref_i` passes through two synchronising registers. Only a 0-to-1 transition counts as an event, so a level held high for many cycles produces exactly one event.
- R3: The frame length is F = `cfg_oct_m1_i`+1 cycles. `frame_stb_o` is high for exactly the cycles in which the octet position is 0.
- R4: `frame_idx_o` counts 0 to K-1, with K = `cfg_frm_m1_i`+1, and advances when the octet position wraps. `mf_stb_o` is high only in a cycle with octet position 0 and frame index 0, and is one cycle wide whenever K·F > 1.
- R5: Suppose `sysref_i` is low in one cycle, is driven high, and is first sampled high at edge E. If that event is accepted, the cycle after edge E+2 shows octet position 0 and frame index 0: `mf_stb_o`=1 and `frame_idx_o`=0. Counting then continues from there.
- R6: `aligned_o` rises with the first accepted event and stays high until reset. `adjusted_o` is 0 if the last accepted event fell where the counter would have wrapped to position 0/0 anyway, and 1 otherwise.
- R7: With `cfg_cont_i`=1 every event is accepted. With `cfg_cont_i`=0 only the first event after arming is accepted. The block is armed out of reset, and a one-cycle pulse on `arm_i` re-arms it.
- R8: `release_o` is high for one cycle at octet position 0 of frame index `cfg_rel_off_i`, and only while the block is aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link character clock, one octet per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sysref_i | input | 1 | External system reference, asynchronous |
| arm_i | input | 1 | Re-arm pulse for the one-shot mode |
| cfg_cont_i | input | 1 | 1 = accept every event, 0 = accept the first event after arming |
| cfg_oct_m1_i | input | OCT_W | Octets per frame minus one |
| cfg_frm_m1_i | input | FRM_W | Frames per multiframe minus one |
| cfg_rel_off_i | input | FRM_W | Frame index at which buffered data is released |
| frame_stb_o | output | 1 | Frame boundary strobe |
| mf_stb_o | output | 1 | Multiframe boundary strobe |
| frame_idx_o | output | FRM_W | Current frame index within the multiframe |
| aligned_o | output | 1 | An accepted reference event has occurred |
| adjusted_o | output | 1 | The last accepted event moved the phase |
| release_o | output | 1 | Elastic buffer release strobe |

## Verification
The bench builds the block with OCT_W=4 and FRM_W=3, which allows frames of up to 16 octets and multiframes of up to 8 frames. With these widths the extreme settings are quick to reach. The single-octet frame, the single-frame multiframe, the widest frame and a release offset at the last frame index each complete many full multiframes within a short run. Off-boundary and on-boundary reference edges are placed by predicting the counter three cycles ahead, so both outcomes of the adjusted flag and the ignored edge in one-shot mode are checked at exact cycles.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_CONT    = 1'b1
  } mfa_mode_e;
endpackage

// File: rtl/mfa_sref_det.sv
module mfa_sref_det #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sref_i,
  output logic edge_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], sref_i};
      hist_q <= sync_q[SYNC_N-1];
    end
  end

  assign edge_o = sync_q[SYNC_N-1] & ~hist_q;

  // R2: a level held high cannot yield events in consecutive cycles
  a_r2_single_event: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/mfa_lmfc_cnt.sv
module mfa_lmfc_cnt #(
  parameter int OCT_W = 8,
  parameter int FRM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCT_W-1:0] oct_m1,
  input  logic [FRM_W-1:0] frm_m1,
  input  logic             realign,
  output logic             nat_wrap_o,
  output logic [OCT_W-1:0] oct_d_o,
  output logic [FRM_W-1:0] frm_d_o,
  output logic [FRM_W-1:0] frm_q_o,
  output logic             frame_stb_o,
  output logic             mf_stb_o
);
  logic [OCT_W-1:0] oct_q, nat_oct;
  logic [FRM_W-1:0] frm_q, nat_frm;

  always_comb begin
    nat_oct = oct_q + 1'b1;
    nat_frm = frm_q;
    if (oct_q >= oct_m1) begin
      nat_oct = '0;
      nat_frm = (frm_q >= frm_m1) ? '0 : frm_q + 1'b1;
    end
    nat_wrap_o = (nat_oct == '0) && (nat_frm == '0);
    oct_d_o    = realign ? '0 : nat_oct;
    frm_d_o    = realign ? '0 : nat_frm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oct_q       <= '0;
      frm_q       <= '0;
      frame_stb_o <= 1'b0;
      mf_stb_o    <= 1'b0;
    end else begin
      oct_q       <= oct_d_o;
      frm_q       <= frm_d_o;
      frame_stb_o <= (oct_d_o == '0);
      mf_stb_o    <= (oct_d_o == '0) && (frm_d_o == '0);
    end
  end

  assign frm_q_o = frm_q;

  // R5: a realign request puts the counter at the multiframe start
  a_r5_realign_zero: assert property (@(posedge clk) disable iff (rst)
    realign |=> (oct_q == '0) && (frm_q == '0));

  // R4: multiframe strobe lasts one cycle when a multiframe is longer than one octet
  a_r4_mf_single: assert property (@(posedge clk) disable iff (rst)
    (mf_stb_o && !realign && ((oct_m1 != '0) || (frm_m1 != '0))) |=> !mf_stb_o);
endmodule

// File: rtl/mfa_release.sv
module mfa_release #(
  parameter int OCT_W = 8,
  parameter int FRM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCT_W-1:0] oct_d,
  input  logic [FRM_W-1:0] frm_d,
  input  logic [FRM_W-1:0] rel_off,
  input  logic             aligned_d,
  output logic             release_o
);
  always_ff @(posedge clk) begin
    if (rst) release_o <= 1'b0;
    else     release_o <= aligned_d && (oct_d == '0) && (frm_d == rel_off);
  end
endmodule

// File: rtl/mfclk_align.sv
module mfclk_align
  import mfa_pkg::*;
#(
  parameter int OCT_W  = 8,
  parameter int FRM_W  = 5,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sysref_i,
  input  logic             arm_i,
  input  logic             cfg_cont_i,
  input  logic [OCT_W-1:0] cfg_oct_m1_i,
  input  logic [FRM_W-1:0] cfg_frm_m1_i,
  input  logic [FRM_W-1:0] cfg_rel_off_i,
  output logic             frame_stb_o,
  output logic             mf_stb_o,
  output logic [FRM_W-1:0] frame_idx_o,
  output logic             aligned_o,
  output logic             adjusted_o,
  output logic             release_o
);
  mfa_mode_e        mode;
  logic             sref_edge, accept, armed_q, nat_wrap, aligned_d;
  logic [OCT_W-1:0] oct_d;
  logic [FRM_W-1:0] frm_d;

  assign mode      = mfa_mode_e'(cfg_cont_i);
  assign accept    = sref_edge && ((mode == MODE_CONT) || armed_q);
  assign aligned_d = aligned_o | accept;

  mfa_sref_det #(.SYNC_N(SYNC_N)) i_det (
    .clk(clk), .rst(rst), .sref_i(sysref_i), .edge_o(sref_edge)
  );

  mfa_lmfc_cnt #(.OCT_W(OCT_W), .FRM_W(FRM_W)) i_cnt (
    .clk(clk), .rst(rst), .oct_m1(cfg_oct_m1_i), .frm_m1(cfg_frm_m1_i),
    .realign(accept), .nat_wrap_o(nat_wrap), .oct_d_o(oct_d), .frm_d_o(frm_d),
    .frm_q_o(frame_idx_o), .frame_stb_o(frame_stb_o), .mf_stb_o(mf_stb_o)
  );

  mfa_release #(.OCT_W(OCT_W), .FRM_W(FRM_W)) i_rel (
    .clk(clk), .rst(rst), .oct_d(oct_d), .frm_d(frm_d),
    .rel_off(cfg_rel_off_i), .aligned_d(aligned_d), .release_o(release_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b1;
      aligned_o  <= 1'b0;
      adjusted_o <= 1'b0;
    end else begin
      if (arm_i)                                armed_q <= 1'b1;
      else if (accept && mode == MODE_ONESHOT)  armed_q <= 1'b0;
      if (accept) begin
        aligned_o  <= 1'b1;
        adjusted_o <= ~nat_wrap;
      end
    end
  end

  // R6: alignment is sticky until reset
  a_r6_aligned_sticky: assert property (@(posedge clk) disable iff (rst)
    aligned_o |=> aligned_o);

  // R5: an accepted event shows as a multiframe start in the next cycle
  a_r5_accept_boundary: assert property (@(posedge clk) disable iff (rst)
    accept |=> aligned_o && mf_stb_o && (frame_idx_o == '0));

  // R7: one-shot mode consumes the arming
  a_r7_oneshot_disarm: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == MODE_ONESHOT && !arm_i) |=> !armed_q);

  // R8: no release before alignment
  a_r8_release_aligned: assert property (@(posedge clk) disable iff (rst)
    release_o |-> aligned_o);
endmodule

// File: tb/test_mfclk_align.sv
module test_mfclk_align;
  localparam int OW = 4;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sysref = 1'b0, arm = 1'b0, cont = 1'b1;
  logic [OW-1:0] om1 = 4'd3;
  logic [FW-1:0] fm1 = 3'd3, rel = 3'd2;
  logic frame_stb, mf_stb, aligned, adjusted, release_s;
  logic [FW-1:0] idx;

  always #5 clk = ~clk;

  mfclk_align #(.OCT_W(OW), .FRM_W(FW)) i_mfclk_align (
    .clk(clk), .rst(rst), .sysref_i(sysref), .arm_i(arm), .cfg_cont_i(cont),
    .cfg_oct_m1_i(om1), .cfg_frm_m1_i(fm1), .cfg_rel_off_i(rel),
    .frame_stb_o(frame_stb), .mf_stb_o(mf_stb), .frame_idx_o(idx),
    .aligned_o(aligned), .adjusted_o(adjusted), .release_o(release_s)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct { int when; bit exp_mf; bit chk_adj; bit exp_adj; string tag; } sb_item_t;
  sb_item_t sbq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void adv1(input int o, input int f, output int no, output int nf);
    if (o >= int'(om1)) begin
      no = 0;
      nf = (f >= int'(fm1)) ? 0 : f + 1;
    end else begin
      no = o + 1;
      nf = f;
    end
  endfunction

  // behavioural reference from the requirements
  logic [2:0] msh;
  int mo, mf;
  bit marmed, maligned, madj, live;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      msh <= '0; mo <= 0; mf <= 0; marmed <= 1; maligned <= 0; madj <= 0; live <= 0;
    end else begin : mdl
      bit ev, acc;
      int no, nf;
      ev  = msh[1] & ~msh[2];
      acc = ev && (cont || marmed);
      adv1(mo, mf, no, nf);
      msh <= {msh[1:0], sysref};
      if (acc) begin
        madj <= !(no == 0 && nf == 0);
        maligned <= 1;
        mo <= 0; mf <= 0;
      end else begin
        mo <= no; mf <= nf;
      end
      if (arm) marmed <= 1;
      else if (acc && !cont) marmed <= 0;
      live <= 1;
    end
  end

  // monitor: per-cycle comparison and scoreboard pop
  always @(negedge clk) begin
    if (!done) begin
      string p;
      bit e_fs, e_mf, e_rel;
      p = rst ? "R1 " : "";
      e_fs  = live && mo == 0;
      e_mf  = live && mo == 0 && mf == 0;
      e_rel = live && maligned && mo == 0 && mf == int'(rel);
      chk(frame_stb == e_fs, {p, "R3 frame_stb"}, frame_stb, e_fs);
      chk(mf_stb == e_mf, {p, "R4/R2 mf_stb"}, mf_stb, e_mf);
      chk(int'(idx) == mf, {p, "R4 frame_idx"}, idx, mf);
      chk(aligned == maligned, {p, "R6 aligned"}, aligned, maligned);
      chk(adjusted == madj, {p, "R6 adjusted"}, adjusted, madj);
      chk(release_s == e_rel, {p, "R8 release"}, release_s, e_rel);
      if (sbq.size() > 0 && sbq[0].when == cyc) begin
        sb_item_t it;
        it = sbq.pop_front();
        chk(mf_stb == it.exp_mf, {it.tag, " sb mf_stb"}, mf_stb, it.exp_mf);
        if (it.exp_mf) chk(idx == '0, {it.tag, " sb frame_idx"}, idx, 0);
        if (it.chk_adj) begin
          chk(adjusted == it.exp_adj, {"R6 sb adjusted ", it.tag}, adjusted, it.exp_adj);
          chk(aligned == 1'b1, {"R6 sb aligned ", it.tag}, aligned, 1);
        end
      end
    end
  end

  function automatic bit bnd3();
    int o, f, no, nf;
    o = mo; f = mf;
    for (int i = 0; i < 3; i++) begin
      adv1(o, f, no, nf);
      o = no; f = nf;
    end
    return (o == 0 && f == 0);
  endfunction

  // driver: one reference pulse, expected outcome pushed to the scoreboard
  task automatic pulse(input int hold, input string tag);
    sb_item_t it;
    bit acc, b;
    acc = cont || marmed;
    b = bnd3();
    it.when = cyc + 3;
    it.exp_mf = acc ? 1'b1 : b;
    it.chk_adj = acc;
    it.exp_adj = !b;
    it.tag = tag;
    sbq.push_back(it);
    sysref = 1'b1;
    repeat (hold) @(negedge clk);
    sysref = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_pos(input bit want_bnd);
    while (bnd3() != want_bnd) @(negedge clk);
  endtask

  task automatic restart(input int o, input int f, input int r, input bit c);
    rst = 1'b1;
    om1 = OW'(o); fm1 = FW'(f); rel = FW'(r); cont = c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    restart(3, 3, 2, 1);               // R1 checked during reset
    repeat (40) @(negedge clk);        // free run, no release before R8 alignment
    wait_pos(0); pulse(1, "R5 off-boundary");
    repeat (23) @(negedge clk);
    wait_pos(1); pulse(2, "R5 on-boundary");
    repeat (11) @(negedge clk);
    wait_pos(0); pulse(12, "R2 long level");
    repeat (30) @(negedge clk);
    // one-shot mode
    cont = 1'b0;
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    repeat (5) @(negedge clk);
    wait_pos(0); pulse(1, "R7 first after arm");
    repeat (7) @(negedge clk);
    wait_pos(0); pulse(1, "R7 ignored when disarmed");
    repeat (9) @(negedge clk);
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    wait_pos(0); pulse(1, "R7 re-armed");
    repeat (20) @(negedge clk);
    // single-octet frames, longest multiframe, release at last index
    restart(0, 7, 7, 1);
    repeat (13) @(negedge clk);
    wait_pos(0); pulse(1, "R4 F=1 K=8");
    repeat (40) @(negedge clk);
    // widest frame, single-frame multiframe
    restart(15, 0, 0, 1);
    repeat (21) @(negedge clk);
    wait_pos(0); pulse(1, "R3 F=16 K=1");
    repeat (60) @(negedge clk);
    // F=1 K=1: every position is a boundary
    restart(0, 0, 0, 1);
    repeat (5) @(negedge clk);
    pulse(1, "R6 K*F=1");
    repeat (10) @(negedge clk);
    chk(sbq.size() == 0, "R5 scoreboard drained", sbq.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule